// File: doc/BRIEF.md
# Sampling Converter Parallel Port Model

This block is a synthesizable, clock-driven model of the digital side of a 16-bit sampling converter with a parallel bus. Two active-low style controls, a chip select and a read/convert line, are decoded into two kinds of event. A conversion starts when both lines become low, whichever of the two falls last. A read window is open while chip select is low and read/convert is high. A third input chooses the byte order on the data pins.

The code to be "converted" comes from a sample input port. It is captured when the conversion starts. A parameterised timer then drives a busy strobe low and, near the end of the conversion, moves the held code into the result register. Until then the previous result stays on the pins. A level output stands in for the tri-state enable of the data pins. A valid flag marks that at least one conversion has completed since reset. Inputs are synchronised before any decoding, so every response comes a fixed number of clock edges after the input changes.

Top module: `samp_conv_if`

## Requirements
In every timing below, the first rising clock edge that samples a new input level is edge 0. Default parameters are DATA_W=16, SYNC_STAGES=2, CONV_CYC=20, BUSY_DLY=2, VALID_LEAD=2 and READ_IN_CONV=1.
- R1: During and right after reset, busy_n is 1, data_oe is 0, result_valid is 0 and data_o is 0.
- R2: After a conversion start, busy_n goes low at edge SYNC_STAGES+BUSY_DLY (4) and returns high at edge SYNC_STAGES+CONV_CYC+1 (23).
- R3: With rd_cnv already low, a falling cs_n starts a conversion. With cs_n high, a falling rd_cnv does not start one.
- R4: With cs_n held low, a falling rd_cnv starts a conversion.
- R5: While a conversion runs, any activity on cs_n or rd_cnv neither starts a new conversion nor changes the busy timing. busy_n stays low for exactly CONV_CYC+1-BUSY_DLY cycles.
- R6: sample_code is captured at edge SYNC_STAGES. Later changes to it do not affect that conversion's result.
- R7: data_o keeps the previous result during the conversion. It changes to the new result at edge SYNC_STAGES+CONV_CYC-VALID_LEAD+2 (22), one cycle before busy_n rises.
- R8: result_valid is 0 until the first conversion completes. It becomes 1 at edge SYNC_STAGES+CONV_CYC-VALID_LEAD+1 (21) and then stays 1.
- R9: data_oe is 1 only while cs_n is low and rd_cnv is high; reads are allowed during a conversion. It follows the inputs at edge 2.
- R10: With byte_swap=1, data_o carries the result with its upper and lower 8-bit halves exchanged: bits 7:0 of the result appear on data_o[15:8]. With byte_swap=0, the result appears unchanged. A change of byte_swap takes effect at edge 2.
- R11: Codes are 16-bit two's complement and pass through unaltered: 16'h7FFF (positive full scale), 16'h8000 (negative full scale) and 16'h0000 (midscale).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | High selects read, low requests conversion |
| byte_swap | input | 1 | 1 exchanges the two result bytes on data_o |
| sample_code | input | DATA_W | Code taken as the converted value |
| busy_n | output | 1 | Low while a conversion runs |
| data_o | output | DATA_W | Result as presented on the pins |
| data_oe | output | 1 | Output enable standing in for tri-state |
| result_valid | output | 1 | At least one conversion has completed |

## Verification
Each result has a fixed latency from the input edge. The read enable and byte order follow at edge 2. busy_n falls at edge 4. The valid flag rises at edge 21, the new code reaches the pins at edge 22 and busy_n rises at edge 23. Each directed task drives its inputs on a falling clock edge and counts falling edges from that point, so every check is taken on the falling edge just after the rising edge at which the value is due. Where it matters, the cycle before is also checked, to show that the value did not arrive early.

// File: rtl/scv_pkg.sv
package scv_pkg;

   // Control pins after synchronisation, packed in a fixed order
   typedef struct packed {
      logic swap;
      logic rd;
      logic cs_n;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   // Idle values: no swap, read selected, chip deselected
   localparam ctl_t CTL_IDLE = '{swap: 1'b0, rd: 1'b1, cs_n: 1'b1};

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

endpackage

// File: rtl/scv_sync.sv
module scv_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= {STAGES{RST_VAL}};
      end else begin
         stg_q <= {stg_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/scv_seq.sv
module scv_seq
   import scv_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int CONV_CYC   = 20,
   parameter int BUSY_DLY   = 2,
   parameter int VALID_LEAD = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_req_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              active_o,
   output logic              busy_n_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] result_o
);

   localparam int            CNT_W    = $clog2(CONV_CYC + 1);
   localparam logic [CNT_W-1:0] BUSY_AT  = CNT_W'(BUSY_DLY - 1);
   localparam logic [CNT_W-1:0] LATCH_AT = CNT_W'(CONV_CYC - VALID_LEAD);
   localparam logic [CNT_W-1:0] END_AT   = CNT_W'(CONV_CYC);

   seq_state_t        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              req_d_q;
   logic              start;
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] result_q;
   logic              busy_n_q;
   logic              valid_q;

   // A new request level that is not a continuation of the previous one
   assign start = conv_req_i & ~req_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_d_q <= 1'b0;
      end else begin
         req_d_q <= conv_req_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_IDLE;
         cnt_q    <= '0;
         hold_q   <= '0;
         result_q <= '0;
         busy_n_q <= 1'b1;
         valid_q  <= 1'b0;
      end else begin
         unique case (st_q)
            SEQ_IDLE: begin
               if (start) begin
                  st_q   <= SEQ_RUN;
                  cnt_q  <= '0;
                  hold_q <= sample_i;
               end
            end
            SEQ_RUN: begin
               // Requests are deliberately not looked at in this state
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == BUSY_AT) begin
                  busy_n_q <= 1'b0;
               end
               if (cnt_q == LATCH_AT) begin
                  result_q <= hold_q;
                  valid_q  <= 1'b1;
               end
               if (cnt_q == END_AT) begin
                  st_q     <= SEQ_IDLE;
                  cnt_q    <= '0;
                  busy_n_q <= 1'b1;
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign active_o = (st_q == SEQ_RUN);
   assign busy_n_o = busy_n_q;
   assign valid_o  = valid_q;
   assign result_o = result_q;

endmodule

// File: rtl/scv_outbus.sv
module scv_outbus #(
   parameter int DATA_W       = 16,
   parameter bit READ_IN_CONV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] result_i,
   input  logic              swap_i,
   input  logic              cs_n_i,
   input  logic              rd_i,
   input  logic              active_i,
   output logic [DATA_W-1:0] data_o,
   output logic              oe_o
);

   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] swapped;
   logic              rd_ok;
   logic [DATA_W-1:0] data_q;
   logic              oe_q;

   // Half exchange: bit i of the pins takes result bit (i + HALF) mod DATA_W
   for (genvar i = 0; i < DATA_W; i++) begin : g_swap
      assign swapped[i] = result_i[(i + HALF) % DATA_W];
   end

   assign rd_ok = READ_IN_CONV | ~active_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         oe_q   <= 1'b0;
      end else begin
         data_q <= swap_i ? swapped : result_i;
         oe_q   <= ~cs_n_i & rd_i & rd_ok;
      end
   end

   assign data_o = data_q;
   assign oe_o   = oe_q;

endmodule

// File: rtl/samp_conv_if.sv
module samp_conv_if
   import scv_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int CONV_CYC     = 20,
   parameter int BUSY_DLY     = 2,
   parameter int VALID_LEAD   = 2,
   parameter bit READ_IN_CONV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_cnv,
   input  logic              byte_swap,
   input  logic [DATA_W-1:0] sample_code,
   output logic              busy_n,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe,
   output logic              result_valid
);

   // Elaboration-time parameter checks
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("samp_conv_if: DATA_W must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("samp_conv_if: SYNC_STAGES must be at least 2");
   end
   if (BUSY_DLY < 1) begin : g_bad_busy
      $error("samp_conv_if: BUSY_DLY must be at least 1");
   end
   if (VALID_LEAD < 1) begin : g_bad_lead
      $error("samp_conv_if: VALID_LEAD must be at least 1");
   end
   if (BUSY_DLY >= CONV_CYC - VALID_LEAD) begin : g_bad_order
      $error("samp_conv_if: busy must fall before the result is latched");
   end

   ctl_t              ctl_raw;
   logic [CTL_W-1:0]  ctl_sync_vec;
   ctl_t              ctl_s;
   logic              conv_req;
   logic              active;
   logic [DATA_W-1:0] result;

   assign ctl_raw = '{swap: byte_swap, rd: rd_cnv, cs_n: cs_n};

   scv_sync #(
      .WIDTH   (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTL_IDLE)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ctl_raw),
      .sync_o  (ctl_sync_vec)
   );

   assign ctl_s = ctl_t'(ctl_sync_vec);

   // Chip select and read/convert combine: both low means conversion request
   assign conv_req = ~ctl_s.cs_n & ~ctl_s.rd;

   scv_seq #(
      .DATA_W     (DATA_W),
      .CONV_CYC   (CONV_CYC),
      .BUSY_DLY   (BUSY_DLY),
      .VALID_LEAD (VALID_LEAD)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_req_i (conv_req),
      .sample_i   (sample_code),
      .active_o   (active),
      .busy_n_o   (busy_n),
      .valid_o    (result_valid),
      .result_o   (result)
   );

   scv_outbus #(
      .DATA_W       (DATA_W),
      .READ_IN_CONV (READ_IN_CONV)
   ) i_outbus (
      .clk      (clk),
      .rst_n    (rst_n),
      .result_i (result),
      .swap_i   (ctl_s.swap),
      .cs_n_i   (ctl_s.cs_n),
      .rd_i     (ctl_s.rd),
      .active_i (active),
      .data_o   (data_o),
      .oe_o     (data_oe)
   );

endmodule

// File: rtl/samp_conv_chk.sv
module samp_conv_chk #(
   parameter int CONV_CYC = 20,
   parameter int BUSY_DLY = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic rd_cnv,
   input logic busy_n,
   input logic data_oe,
   input logic result_valid
);

   localparam int LOW_LEN = CONV_CYC + 1 - BUSY_DLY;

   int low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= 0;
      end else if (busy_n) begin
         low_cnt <= 0;
      end else begin
         low_cnt <= low_cnt + 1;
      end
   end

   // R5: a busy pulse is never stretched or cut by commands
   a_r5_busy_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> (low_cnt == LOW_LEN));

   // R2: the end of busy always comes with a valid result
   a_r2_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> result_valid);

   // R8: once valid, always valid until reset
   a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> result_valid);

   // R9: output enable only follows a selected read three samples back
   a_r9_oe_decode: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (!$past(cs_n, 3) && $past(rd_cnv, 3)));

endmodule

bind samp_conv_if samp_conv_chk #(
   .CONV_CYC (CONV_CYC),
   .BUSY_DLY (BUSY_DLY)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n         (cs_n),
   .rd_cnv       (rd_cnv),
   .busy_n       (busy_n),
   .data_oe      (data_oe),
   .result_valid (result_valid)
);

// File: tb/test_samp_conv_if.sv
`timescale 1ns/1ps
module test_samp_conv_if;

   // Edge numbers taken from the requirements (default parameters)
   localparam int E_OE    = 2;
   localparam int E_BLOW  = 4;
   localparam int E_VALID = 21;
   localparam int E_DATA  = 22;
   localparam int E_BHIGH = 23;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_cnv = 1'b1;
   logic        byte_swap = 1'b0;
   logic [15:0] sample_code = 16'h0000;
   logic        busy_n;
   logic [15:0] data_o;
   logic        data_oe;
   logic        result_valid;

   int n_chk = 0;
   int n_err = 0;
   int t = 0;

   always #2.5 clk = ~clk;

   samp_conv_if i_samp_conv_if (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n         (cs_n),
      .rd_cnv       (rd_cnv),
      .byte_swap    (byte_swap),
      .sample_code  (sample_code),
      .busy_n       (busy_n),
      .data_o       (data_o),
      .data_oe      (data_oe),
      .result_valid (result_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h (t=%0d)", req, act, exp, t);
      end
   endtask

   // Restart the edge count: inputs just driven on a falling edge
   task automatic mark();
      t = 0;
   endtask

   // Wait until the falling edge just after rising edge number e
   task automatic upto(input int e);
      while (t < e + 1) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic test_reset();
      chk("R1 busy_n", busy_n, 1);
      chk("R1 data_oe", data_oe, 0);
      chk("R1 result_valid", result_valid, 0);
      chk("R1 data_o", data_o, 16'h0000);
   endtask

   // Conversion started by read/convert with chip select low
   task automatic test_rd_start();
      cs_n = 1'b0; rd_cnv = 1'b1;
      idle(4);
      chk("R9 oe on read", data_oe, 1);
      sample_code = 16'h1234;
      rd_cnv = 1'b0; mark();
      upto(E_OE - 1);
      chk("R9 oe before edge", data_oe, 1);
      upto(E_OE);
      chk("R9 oe off on convert", data_oe, 0);
      upto(E_BLOW - 1);
      chk("R2 busy not early", busy_n, 1);
      upto(E_BLOW);
      chk("R4 busy low", busy_n, 0);
      rd_cnv = 1'b1;
      upto(E_VALID - 1);
      chk("R8 not valid yet", result_valid, 0);
      chk("R7 previous data", data_o, 16'h0000);
      upto(E_VALID);
      chk("R8 valid", result_valid, 1);
      upto(E_DATA);
      chk("R7 new data", data_o, 16'h1234);
      chk("R7 busy still low", busy_n, 0);
      upto(E_BHIGH);
      chk("R2 busy high", busy_n, 1);
      chk("R9 oe on after", data_oe, 1);
   endtask

   // Conversion started by chip select with read/convert low
   task automatic test_cs_start();
      cs_n = 1'b1; rd_cnv = 1'b1;
      idle(4);
      sample_code = 16'h7FFF;
      rd_cnv = 1'b0; mark();
      upto(8);
      chk("R3 no start with cs high", busy_n, 1);
      cs_n = 1'b0; mark();
      upto(E_BLOW);
      chk("R3 busy low", busy_n, 0);
      sample_code = 16'h0001;
      cs_n = 1'b1; rd_cnv = 1'b1;
      upto(E_DATA);
      chk("R6 held sample", data_o, 16'h7FFF);
      chk("R11 positive full scale", data_o, 16'h7FFF);
      upto(E_BHIGH);
      chk("R2 busy high", busy_n, 1);
      chk("R8 stays valid", result_valid, 1);
   endtask

   // Commands during a conversion are ignored
   task automatic test_ignore();
      cs_n = 1'b0; rd_cnv = 1'b1;
      idle(4);
      sample_code = 16'h8000;
      rd_cnv = 1'b0; mark();
      upto(7);
      chk("R5 busy low", busy_n, 0);
      rd_cnv = 1'b1;
      upto(10);
      chk("R7 previous data in conv", data_o, 16'h7FFF);
      chk("R9 read during conv", data_oe, 1);
      rd_cnv = 1'b0;
      sample_code = 16'h5555;
      upto(14);
      cs_n = 1'b1;
      upto(16);
      cs_n = 1'b0;
      upto(E_DATA);
      chk("R5 result unchanged", data_o, 16'h8000);
      chk("R11 negative full scale", data_o, 16'h8000);
      upto(E_BHIGH - 1);
      chk("R5 busy not extended early", busy_n, 0);
      upto(E_BHIGH);
      chk("R5 busy ends on time", busy_n, 1);
      rd_cnv = 1'b1;
      upto(E_BHIGH + 12);
      chk("R5 no late restart", busy_n, 1);
   endtask

   task automatic run_conv(input logic [15:0] code);
      cs_n = 1'b0; rd_cnv = 1'b1;
      idle(4);
      sample_code = code;
      rd_cnv = 1'b0; mark();
      upto(E_BLOW);
      rd_cnv = 1'b1;
      upto(E_BHIGH + 1);
   endtask

   task automatic test_midscale();
      run_conv(16'h0000);
      chk("R11 midscale", data_o, 16'h0000);
   endtask

   task automatic test_swap();
      run_conv(16'h12AB);
      chk("R10 normal order", data_o, 16'h12AB);
      byte_swap = 1'b1; mark();
      upto(E_OE - 1);
      chk("R10 swap not early", data_o, 16'h12AB);
      upto(E_OE);
      chk("R10 swapped", data_o, 16'hAB12);
      byte_swap = 1'b0; mark();
      upto(E_OE);
      chk("R10 swap back", data_o, 16'h12AB);
   endtask

   task automatic test_oe();
      cs_n = 1'b1; rd_cnv = 1'b1; mark();
      upto(E_OE);
      chk("R9 oe off cs high", data_oe, 0);
      rd_cnv = 1'b0; mark();
      upto(E_OE);
      chk("R9 oe off rd low", data_oe, 0);
      chk("R3 no start cs high", busy_n, 1);
      rd_cnv = 1'b1; mark();
      upto(E_OE);
      chk("R9 oe off cs still high", data_oe, 0);
      cs_n = 1'b0; mark();
      upto(E_OE - 1);
      chk("R9 oe not early", data_oe, 0);
      upto(E_OE);
      chk("R9 oe on", data_oe, 1);
   endtask

   initial begin
      idle(5);
      test_reset();
      rst_n = 1'b1;
      idle(2);
      test_reset();
      test_rd_start();
      test_cs_start();
      test_ignore();
      test_midscale();
      test_swap();
      test_oe();
      idle(4);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1..all: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule